// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs a fixed-length measurement cycle made of four phases in a fixed order: auto-zero, signal integration, reference de-integration and integrator zeroing. Each phase closes one of four analog switch controls. During de-integration the block watches a comparator that reports the sign of the integrator output. It counts reference clocks until the integrator crosses back through zero, and the number of counted clocks is the magnitude of the reading.

At the end of a measurement the block presents the magnitude as packed BCD digits together with a sign bit. It raises a single-cycle valid strobe and updates the busy, overrange and underrange flags. The de-integration counter is held off for the first de-integration clock. This cancels the one-clock delay that comes from registering the comparator. With run/hold held high the block converts continuously. With run/hold low it finishes the cycle in progress and keeps the last reading until run/hold is seen high again. The integrator, comparator and reference are outside the block.

Top module: `dual_slope_seq`

## Requirements
- R1: `sw_o` is always one-hot, with bit 0 for auto-zero, bit 1 for signal integration, bit 2 for de-integration and bit 3 for zeroing. Phases follow only the order auto-zero, integration, de-integration, zeroing, auto-zero.
- R2: Signal integration lasts exactly `INT_CLKS` clocks. While `run_hold_i` stays high, integration starts every `CYCLE_CLKS` clocks.
- R3: The first de-integration clock is never counted. If the comparator output differs from the latched polarity from the end of the N-th counted position onward, de-integration lasts N+2 clocks and the reading is N. `res_bcd_o` holds it as decimal digits, with digit d in bits [4d+3:4d] and the least significant digit in bits [3:0].
- R4: Polarity is sampled from `cmp_i` (high means positive integrator output) at the edge that starts de-integration. `pol_o` changes only at that edge and is high for a positive input. `res_neg_o` is high for a non-positive result.
- R5: `busy_o` rises with the start of integration. For an in-range input it falls at the same edge as the switch from de-integration to zeroing.
- R6: If the count would pass `FS_COUNTS`, de-integration stops after `FS_COUNTS`+2 clocks with a reading of `FS_COUNTS`+1. Zeroing is then extended from `ZERO_CLKS` to `OVR_ZERO_CLKS`, and busy falls only when that zeroing ends. `over_o` rises with that busy fall and clears at the start of the next de-integration.
- R7: `under_o` rises when busy falls on an in-range reading of `UNDER_COUNTS` or less. It clears at the start of the next integration. It is never high together with `over_o`.
- R8: `valid_o` is high for exactly one clock per measurement, in the clock right after busy falls. The reading, sign and flags are updated at that same edge.
- R9: `run_hold_i` is only looked at once the cycle has completed. A high level then starts a new cycle. A pulse that comes and goes during a cycle is ignored, and with `run_hold_i` low the block stays in auto-zero.
- R10: During reset `sw_o` is 4'b0001 and busy, valid, overrange, underrange and the reading are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_hold_i | input | 1 | High: convert continuously; low: hold after current cycle |
| cmp_i | input | 1 | Comparator, high when integrator output is positive |
| sw_o | output | 4 | One-hot analog switch controls (auto-zero, integrate, de-integrate, zero) |
| busy_o | output | 1 | Conversion in progress |
| pol_o | output | 1 | Input polarity, high for positive |
| over_o | output | 1 | Last reading exceeded full scale |
| under_o | output | 1 | Last reading at or below the low threshold |
| valid_o | output | 1 | One-clock strobe for a new reading |
| res_neg_o | output | 1 | Sign of the reading, high for non-positive |
| res_bcd_o | output | 4*digits | Reading magnitude as packed BCD |

## Verification
The bench replaces the analog parts with an integer ramp and sweeps every input from beyond negative full scale to beyond positive full scale in a reduced configuration. This sweep covers the zero reading, the low-threshold edge, exact full scale and one step past it. Positive and negative inputs check that the comparator sense and the polarity latch agree. The sweep order moves from overrange to in-range and from underrange to normal, so each flag is seen both set and cleared at its own phase edge. Held-high operation checks the cycle period. A run/hold pulse injected during integration or de-integration must not start an extra cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [1:0] {
      PH_AZ    = 2'd0,
      PH_INT   = 2'd1,
      PH_DEINT = 2'd2,
      PH_ZERO  = 2'd3
   } phase_t;

   // number of decimal digits needed to show a non-negative value
   function automatic int dec_digits(input int val);
      int n;
      int v;
      n = 1;
      v = val;
      while (v >= 10) begin
         v = v / 10;
         n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/dsc_seq.sv
module dsc_seq
   import dsc_pkg::*;
#(
   parameter int CYCLE_CLKS    = 40002,
   parameter int INT_CLKS      = 10000,
   parameter int ZERO_CLKS     = 150,
   parameter int OVR_ZERO_CLKS = 6200
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   run_hold,
   input  logic   deint_done,
   input  logic   deint_ovr,
   output phase_t phase,
   output logic   ev_int_start,
   output logic   ev_deint_start,
   output logic   ev_zero_end
);

   localparam int CYC_W = $clog2(CYCLE_CLKS);
   localparam int ZC_W  = $clog2(OVR_ZERO_CLKS + 1);
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLE_CLKS - 1);
   localparam logic [CYC_W-1:0] INT_LAST = CYC_W'(INT_CLKS - 1);

   logic [CYC_W-1:0] cyc;
   logic [ZC_W-1:0]  zcnt;
   logic [ZC_W-1:0]  zlast;
   logic             long_zero;

   assign zlast = long_zero ? ZC_W'(OVR_ZERO_CLKS - 1) : ZC_W'(ZERO_CLKS - 1);

   assign ev_int_start   = (phase == PH_AZ)   && (cyc == CYC_LAST) && run_hold;
   assign ev_deint_start = (phase == PH_INT)  && (cyc == INT_LAST);
   assign ev_zero_end    = (phase == PH_ZERO) && (zcnt == zlast);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_AZ;
         cyc       <= CYC_LAST;
         zcnt      <= '0;
         long_zero <= 1'b0;
      end else begin
         // cycle position; parks at the last position while holding
         if (phase == PH_AZ && cyc == CYC_LAST) begin
            if (run_hold) begin
               phase <= PH_INT;
               cyc   <= '0;
            end
         end else begin
            cyc <= cyc + 1'b1;
         end
         case (phase)
            PH_INT: begin
               if (ev_deint_start) phase <= PH_DEINT;
            end
            PH_DEINT: begin
               if (deint_done) begin
                  phase     <= PH_ZERO;
                  zcnt      <= '0;
                  long_zero <= deint_ovr;
               end
            end
            PH_ZERO: begin
               zcnt <= zcnt + 1'b1;
               if (ev_zero_end) phase <= PH_AZ;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dsc_deint_cnt.sv
module dsc_deint_cnt #(
   parameter int FS_COUNTS = 20000,
   parameter int CNT_W     = $clog2(FS_COUNTS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_i,
   input  logic             start,
   input  logic             active,
   output logic             pol,
   output logic [CNT_W-1:0] cnt,
   output logic             done,
   output logic             ovr
);

   localparam logic [CNT_W-1:0] CNT_FS = CNT_W'(FS_COUNTS);

   logic cmp_q;
   logic first;
   logic crossed;

   assign crossed = (cmp_q != pol);
   assign done    = active && !first && (crossed || cnt == CNT_FS);
   assign ovr     = active && !first && !crossed && (cnt == CNT_FS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= 1'b0;
         first <= 1'b1;
         cnt   <= '0;
         pol   <= 1'b0;
      end else begin
         cmp_q <= cmp_i;
         if (start) begin
            pol   <= cmp_i;
            cnt   <= '0;
            first <= 1'b1;
         end else if (active) begin
            if (first)         first <= 1'b0;
            else if (!crossed) cnt   <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dsc_flags.sv
module dsc_flags #(
   parameter int CNT_W        = 15,
   parameter int UNDER_COUNTS = 1800
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_int_start,
   input  logic             ev_deint_start,
   input  logic             deint_done,
   input  logic             deint_ovr,
   input  logic             ev_zero_end,
   input  logic [CNT_W-1:0] cnt,
   input  logic             pol,
   output logic             busy,
   output logic             over,
   output logic             under,
   output logic             valid,
   output logic             res_neg,
   output logic [CNT_W-1:0] res_cnt
);

   localparam logic [CNT_W-1:0] UNDER_LIM = CNT_W'(UNDER_COUNTS);

   logic pend;
   logic finish;

   assign finish = (deint_done && !deint_ovr) || (ev_zero_end && pend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         over    <= 1'b0;
         under   <= 1'b0;
         valid   <= 1'b0;
         res_neg <= 1'b0;
         res_cnt <= '0;
         pend    <= 1'b0;
      end else begin
         valid <= finish;
         if (ev_int_start) busy <= 1'b1;
         else if (finish)  busy <= 1'b0;
         if (deint_done && deint_ovr) pend <= 1'b1;
         else if (ev_zero_end)        pend <= 1'b0;
         if (finish) begin
            res_cnt <= cnt;
            res_neg <= !pol;
            over    <= pend;
            under   <= !pend && (cnt <= UNDER_LIM);
         end else begin
            if (ev_deint_start) over  <= 1'b0;
            if (ev_int_start)   under <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dsc_bin2bcd.sv
module dsc_bin2bcd #(
   parameter int BIN_W  = 15,
   parameter int DIGITS = 5
) (
   input  logic [BIN_W-1:0]    bin,
   output logic [4*DIGITS-1:0] bcd
);

   logic [4*DIGITS-1:0] acc;

   // shift-and-add-three, most significant bit first
   always_comb begin
      acc = '0;
      for (int i = BIN_W - 1; i >= 0; i--) begin
         for (int d = 0; d < DIGITS; d++) begin
            if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
         end
         acc = {acc[4*DIGITS-2:0], bin[i]};
      end
   end

   assign bcd = acc;

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
   import dsc_pkg::*;
#(
   parameter int INT_CLKS      = 10000,
   parameter int FS_COUNTS     = 20000,
   parameter int CYCLE_CLKS    = 40002,
   parameter int ZERO_CLKS     = 150,
   parameter int OVR_ZERO_CLKS = 6200,
   parameter int UNDER_COUNTS  = 1800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_hold_i,
   input  logic cmp_i,
   output logic [3:0] sw_o,
   output logic busy_o,
   output logic pol_o,
   output logic over_o,
   output logic under_o,
   output logic valid_o,
   output logic res_neg_o,
   output logic [4*dsc_pkg::dec_digits(FS_COUNTS + 1)-1:0] res_bcd_o
);

   localparam int CNT_W  = $clog2(FS_COUNTS + 2);
   localparam int DIGITS = dec_digits(FS_COUNTS + 1);

   // elaboration-time parameter checks
   if (INT_CLKS < 2) begin : g_chk_int
      $error("INT_CLKS must be at least 2");
   end
   if (ZERO_CLKS < 1 || OVR_ZERO_CLKS < ZERO_CLKS) begin : g_chk_zero
      $error("zeroing lengths must satisfy 1 <= ZERO_CLKS <= OVR_ZERO_CLKS");
   end
   if (CYCLE_CLKS < INT_CLKS + FS_COUNTS + OVR_ZERO_CLKS + 3) begin : g_chk_cycle
      $error("CYCLE_CLKS leaves no auto-zero time");
   end
   if (UNDER_COUNTS >= FS_COUNTS) begin : g_chk_under
      $error("UNDER_COUNTS must be below FS_COUNTS");
   end

   phase_t           phase;
   logic             ev_int_start;
   logic             ev_deint_start;
   logic             ev_zero_end;
   logic             deint_done;
   logic             deint_ovr;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] res_cnt;

   dsc_seq #(
      .CYCLE_CLKS   (CYCLE_CLKS),
      .INT_CLKS     (INT_CLKS),
      .ZERO_CLKS    (ZERO_CLKS),
      .OVR_ZERO_CLKS(OVR_ZERO_CLKS)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_hold      (run_hold_i),
      .deint_done    (deint_done),
      .deint_ovr     (deint_ovr),
      .phase         (phase),
      .ev_int_start  (ev_int_start),
      .ev_deint_start(ev_deint_start),
      .ev_zero_end   (ev_zero_end)
   );

   dsc_deint_cnt #(
      .FS_COUNTS(FS_COUNTS),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cmp_i (cmp_i),
      .start (ev_deint_start),
      .active(phase == PH_DEINT),
      .pol   (pol_o),
      .cnt   (cnt),
      .done  (deint_done),
      .ovr   (deint_ovr)
   );

   dsc_flags #(
      .CNT_W       (CNT_W),
      .UNDER_COUNTS(UNDER_COUNTS)
   ) u_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev_int_start  (ev_int_start),
      .ev_deint_start(ev_deint_start),
      .deint_done    (deint_done),
      .deint_ovr     (deint_ovr),
      .ev_zero_end   (ev_zero_end),
      .cnt           (cnt),
      .pol           (pol_o),
      .busy          (busy_o),
      .over          (over_o),
      .under         (under_o),
      .valid         (valid_o),
      .res_neg       (res_neg_o),
      .res_cnt       (res_cnt)
   );

   dsc_bin2bcd #(
      .BIN_W (CNT_W),
      .DIGITS(DIGITS)
   ) u_bcd (
      .bin(res_cnt),
      .bcd(res_bcd_o)
   );

   // one switch control per phase code
   for (genvar g = 0; g < 4; g++) begin : g_sw
      localparam logic [1:0] CODE = 2'(g);
      assign sw_o[g] = (phase == phase_t'(CODE));
   end

endmodule

// File: rtl/dsc_chk.sv
module dsc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] sw_o,
   input logic       busy_o,
   input logic       pol_o,
   input logic       over_o,
   input logic       under_o,
   input logic       valid_o
);

   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sw_o) == 1);

   a_r1_order_int: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_o[1]) |-> $past(sw_o[0]));

   a_r1_order_deint: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_o[2]) |-> $past(sw_o[1]));

   a_r1_order_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_o[3]) |-> $past(sw_o[2]));

   a_r1_order_az: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_o[0]) |-> $past(sw_o[3]));

   a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_o[1]) |-> $rose(busy_o));

   a_r4_pol_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(sw_o[2]) |-> $stable(pol_o));

   a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   a_r8_valid_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $fell(busy_o));

   a_r8_fall_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> valid_o);

   a_r6_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_o[2]) |-> !over_o);

   a_r6_over_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(over_o) |-> valid_o);

   a_r7_under_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_o[1]) |-> !under_o);

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(over_o && under_o));

endmodule

bind dual_slope_seq dsc_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .sw_o   (sw_o),
   .busy_o (busy_o),
   .pol_o  (pol_o),
   .over_o (over_o),
   .under_o(under_o),
   .valid_o(valid_o)
);

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int INT   = 10;
   localparam int FS    = 20;
   localparam int CYCLE = 48;
   localparam int ZERO  = 3;
   localparam int OVRZ  = 7;
   localparam int UNDER = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_hold = 1'b0;
   logic cmp_i;
   logic [3:0] sw_o;
   logic busy_o, pol_o, over_o, under_o, valid_o, res_neg_o;
   logic [7:0] res_bcd_o;

   int total = 0;
   int bad = 0;
   int vin = 0;
   int v = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_slope_seq #(
      .INT_CLKS     (INT),
      .FS_COUNTS    (FS),
      .CYCLE_CLKS   (CYCLE),
      .ZERO_CLKS    (ZERO),
      .OVR_ZERO_CLKS(OVRZ),
      .UNDER_COUNTS (UNDER)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_hold_i(run_hold),
      .cmp_i     (cmp_i),
      .sw_o      (sw_o),
      .busy_o    (busy_o),
      .pol_o     (pol_o),
      .over_o    (over_o),
      .under_o   (under_o),
      .valid_o   (valid_o),
      .res_neg_o (res_neg_o),
      .res_bcd_o (res_bcd_o)
   );

   // behavioural integrator: reaches zero after |vin| reference clocks
   always @(posedge clk) begin
      if (!rst_n)        v <= 0;
      else if (sw_o[1])  v <= v + vin;
      else if (sw_o[2])  v <= pol_o ? v - INT : v + INT;
      else               v <= 0;
   end

   assign cmp_i = sw_o[2] ? (pol_o ? (v > 0) : (v >= 0)) : (v > 0);

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
      end
   endtask

   function automatic int bcd_of(input int n);
      return (n % 10) | (((n / 10) % 10) << 4);
   endfunction

   task automatic run_one(input int x, input int glitch_at);
      int n_int = 0;
      int n_deint = 0;
      int n_zero = 0;
      int n_valid = 0;
      int mag = (x < 0) ? -x : x;
      bit exp_over = (mag > FS);
      int exp_cnt = exp_over ? FS + 1 : mag;
      bit prev_busy = 1'b0;
      logic [3:0] prev_sw = 4'b0001;
      bit first_int = 1'b1;
      bit first_deint = 1'b1;
      bit prev_over = over_o;
      @(negedge clk);
      vin = x;
      run_hold = 1'b1;
      @(negedge clk);
      run_hold = 1'b0;
      for (int k = 0; k < CYCLE + 6; k++) begin
         if (k == glitch_at) run_hold = 1'b1;
         else if (k == glitch_at + 1) run_hold = 1'b0;
         chk($countones(sw_o) == 1, "R1 one-hot switches", int'(sw_o), 1);
         if (sw_o != prev_sw)
            chk(sw_o == {prev_sw[2:0], prev_sw[3]}, "R1 phase order", int'(sw_o),
                int'({prev_sw[2:0], prev_sw[3]}));
         if (sw_o[1]) begin
            n_int++;
            if (first_int) begin
               first_int = 1'b0;
               chk(under_o == 1'b0, "R7 under cleared at integration start", int'(under_o), 0);
               chk(over_o == prev_over, "R6 over held until de-integration", int'(over_o),
                   int'(prev_over));
               chk(busy_o == 1'b1, "R5 busy high at integration start", int'(busy_o), 1);
            end
         end
         if (sw_o[2]) begin
            n_deint++;
            if (first_deint) begin
               first_deint = 1'b0;
               chk(over_o == 1'b0, "R6 over cleared at de-integration start", int'(over_o), 0);
               chk(pol_o == (x > 0), "R4 polarity at de-integration start", int'(pol_o),
                   int'(x > 0));
            end
         end
         if (sw_o[3]) n_zero++;
         if (valid_o) begin
            n_valid++;
            chk(prev_busy && !busy_o, "R5 busy falls with valid", int'(busy_o), 0);
            chk(int'(res_bcd_o) == bcd_of(exp_cnt), "R3 reading", int'(res_bcd_o),
                bcd_of(exp_cnt));
            chk(res_neg_o == (x <= 0), "R4 sign", int'(res_neg_o), int'(x <= 0));
            chk(over_o == exp_over, "R6 overrange flag", int'(over_o), int'(exp_over));
            chk(under_o == (!exp_over && mag <= UNDER), "R7 underrange flag", int'(under_o),
                int'(!exp_over && mag <= UNDER));
            chk(sw_o == (exp_over ? 4'b0001 : 4'b1000), "R5 busy fall phase", int'(sw_o),
                int'(exp_over ? 4'b0001 : 4'b1000));
            chk(prev_sw == (exp_over ? 4'b1000 : 4'b0100), "R5 phase before busy fall",
                int'(prev_sw), int'(exp_over ? 4'b1000 : 4'b0100));
         end
         prev_busy = busy_o;
         prev_sw = sw_o;
         @(negedge clk);
      end
      chk(n_int == INT, "R2 integration length", n_int, INT);
      chk(n_deint == exp_cnt + (exp_over ? 1 : 2), "R3 de-integration length", n_deint,
          exp_cnt + (exp_over ? 1 : 2));
      chk(n_zero == (exp_over ? OVRZ : ZERO), "R6 zeroing length", n_zero,
          exp_over ? OVRZ : ZERO);
      chk(n_valid == 1, "R8 one valid per measurement", n_valid, 1);
      chk(sw_o == 4'b0001 && !busy_o, "R9 holds after cycle", int'(sw_o), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sw_o == 4'b0001, "R10 reset switches", int'(sw_o), 1);
      chk(!busy_o && !valid_o, "R10 reset busy/valid", int'({busy_o, valid_o}), 0);
      chk(!over_o && !under_o, "R10 reset flags", int'({over_o, under_o}), 0);
      chk(res_bcd_o == 8'd0, "R10 reset reading", int'(res_bcd_o), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sw_o == 4'b0001 && !busy_o, "R9 idle with run/hold low", int'(sw_o), 1);

      // sweep every input across both overrange edges
      for (int x = -(FS + 2); x <= FS + 2; x++) begin
         run_one(x, (x == 5) ? 20 : ((x == -7) ? 3 : -1));
      end

      // continuous operation
      begin
         bit pb = busy_o;
         int last = -1;
         int rises = 0;
         @(negedge clk);
         vin = 7;
         run_hold = 1'b1;
         for (int k = 0; k < 4 * CYCLE; k++) begin
            @(negedge clk);
            if (busy_o && !pb) begin
               if (last >= 0) chk(k - last == CYCLE, "R2 cycle period", k - last, CYCLE);
               last = k;
               rises++;
            end
            pb = busy_o;
         end
         chk(rises >= 3, "R2 continuous conversions", rises, 3);
         run_hold = 1'b0;
         repeat (CYCLE + 2) @(negedge clk);
         rises = 0;
         pb = busy_o;
         for (int k = 0; k < 2 * CYCLE; k++) begin
            @(negedge clk);
            if (busy_o && !pb) rises++;
            pb = busy_o;
         end
         chk(rises == 0, "R9 no new cycle while held", rises, 0);
         chk(res_bcd_o == 8'h07 && !res_neg_o, "R9 reading kept while held",
             int'(res_bcd_o), 7);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule